// File: doc/BRIEF.md
# Subvector Element Swizzle Engine

The engine rearranges data held as a vector of short subvectors. For each of VL subvectors it builds a destination subvector of `dst_len` lanes. Every destination lane copies one element from the matching source subvector, and a constant per-lane selector names that element. Source and destination lengths are set independently. A four-lane selector pattern therefore gives a general shuffle, with lanes repeated or reordered, and a destination length of one pulls a single lane out of every source subvector. Elements are 8, 16 or 32 bits wide. Their byte addresses are the register base plus the element index scaled by the element size.

To run an operation, the controller sets the configuration inputs and pulses `start` while the engine is idle. The engine moves one element per accepted write. It reads the source element through a combinational byte-addressed read port and offers it on a write port that uses valid/ready handshaking. While `wr_valid` is high and `wr_ready` is low, the engine holds the write and waits. A one-cycle `done` pulse ends every operation. In the same cycle `err` reports whether the configuration was rejected.

Top module: `swz_engine`

## Requirements
- R1: The element written to destination index `i*dst_len + k` comes from source index `i*src_len + sel[k]`. Lane k's selector occupies bits `[2k+1:2k]` of `sel`. Element addresses are `dst_base + index*size` and `src_base + index*size`.
- R2: A valid operation performs exactly `vl*dst_len` writes. Subvector i runs in ascending order and, inside each subvector, lane k runs in ascending order.
- R3: With `dst_len = 1`, lane 0's selector pulls that one lane from every source subvector into a packed destination.
- R4: Selectors may repeat a source lane and may appear in any order.
- R5: `el_code` 0, 1 and 2 select 8-, 16- and 32-bit elements of 1, 2 and 4 bytes. `rd_data` carries bytes `rd_addr..rd_addr+3` in little-endian order. `wr_data` holds the element zero-extended, and `wr_size` equals `el_code`.
- R6: `src_len` and `dst_len` may differ; for example a source length of 3 and a destination length of 4.
- R7: If a selector of a used lane (k < `dst_len`) is `src_len` or larger, the operation ends with `err` and `done` and makes no writes. Selectors of unused lanes have no effect.
- R8: A `src_len` or `dst_len` of 0 or more than 4, or an `el_code` of 3, is rejected in the same way as in R7.
- R9: While `wr_ready` is high the engine writes one element per clock. While `wr_valid` is high and `wr_ready` is low, `wr_addr` and `wr_data` stay stable until the write is accepted.
- R10: `busy` rises in the cycle after an accepted start and stays high through the `done` cycle. `done` is a single-cycle pulse in the cycle after the last accepted write.
- R11: A `start` pulse while `busy` is high has no effect on the running operation.
- R12: `vl = 0` asserts `done` in the cycle after start, with no writes and no `err`.
- R13: After reset, `busy`, `done`, `err` and `wr_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| vl | input | VLW | Number of subvectors |
| src_len | input | 3 | Source subvector length, 1..4 |
| dst_len | input | 3 | Destination subvector length, 1..4 |
| el_code | input | 2 | Element size: 0=8, 1=16, 2=32 bits |
| sel | input | 8 | Four 2-bit lane selectors, lane k at [2k+1:2k] |
| src_base | input | AW | Source byte base address |
| dst_base | input | AW | Destination byte base address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |
| err | output | 1 | Configuration rejected (with done) |
| rd_en | output | 1 | Read port active |
| rd_addr | output | AW | Source element byte address |
| rd_data | input | 32 | Bytes rd_addr..rd_addr+3, little-endian |
| wr_valid | output | 1 | Write offered |
| wr_ready | input | 1 | Write accepted when high with wr_valid |
| wr_addr | output | AW | Destination element byte address |
| wr_data | output | 32 | Element value, zero-extended |
| wr_size | output | 2 | Element size code for the write |

## Verification
The bench builds the engine with its defaults: AW=16, VLW=7 and four lanes, so selectors are 2 bits wide and lengths 3 bits wide. These values let every selector from 0 to 3 meet every length from 1 to 4, which covers both the selector-equals-length rejection and the accepted case. Length codes 5 to 7 can also be encoded and must be refused. The bench runs operations of up to 20 subvectors at all three element sizes, with `wr_ready` either held high or toggled at random. This exercises both full-rate streaming and held writes under back-pressure.

// File: rtl/swz_pkg.sv
package swz_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } swz_state_t;

  localparam logic [1:0] EL_B8  = 2'd0;
  localparam logic [1:0] EL_B16 = 2'd1;
  localparam logic [1:0] EL_B32 = 2'd2;

  function automatic logic [1:0] size_shift(input logic [1:0] code);
    case (code)
      EL_B8:   size_shift = 2'd0;
      EL_B16:  size_shift = 2'd1;
      default: size_shift = 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/swz_cfg_check.sv
module swz_cfg_check #(
  parameter int MAXL = 4,
  parameter int SELW = 2,
  parameter int LENW = 3
) (
  input  logic [LENW-1:0]      src_len,
  input  logic [LENW-1:0]      dst_len,
  input  logic [1:0]           el_code,
  input  logic [MAXL*SELW-1:0] sel,
  output logic                 bad
);
  logic [MAXL-1:0] lane_bad;

  for (genvar k = 0; k < MAXL; k++) begin : g_lane
    localparam logic [LENW-1:0] KIDX = LENW'(k);
    always_comb begin
      lane_bad[k] = (KIDX < dst_len) &&
                    (LENW'(sel[k*SELW +: SELW]) >= src_len);
    end
  end

  logic len_bad;
  always_comb begin
    len_bad = (src_len == '0) || (src_len > LENW'(MAXL)) ||
              (dst_len == '0) || (dst_len > LENW'(MAXL));
    bad = len_bad || (el_code == 2'd3) || (|lane_bad);
  end
endmodule

// File: rtl/swz_addr_gen.sv
module swz_addr_gen #(
  parameter int AW   = 16,
  parameter int VLW  = 7,
  parameter int MAXL = 4,
  parameter int SELW = 2,
  parameter int LENW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 step,
  input  logic [VLW-1:0]       vl,
  input  logic [LENW-1:0]      sl,
  input  logic [LENW-1:0]      dl,
  input  logic [MAXL*SELW-1:0] sel,
  input  logic [1:0]           shift,
  input  logic [AW-1:0]        src_base,
  input  logic [AW-1:0]        dst_base,
  output logic [AW-1:0]        rd_addr,
  output logic [AW-1:0]        wr_addr,
  output logic                 last
);
  localparam int IDXW = VLW + LENW;

  logic [VLW-1:0]  sub_q;
  logic [SELW-1:0] lane_q;
  logic [IDXW-1:0] sbase_q;
  logic [IDXW-1:0] didx_q;
  logic            lane_end;

  always_comb begin
    lane_end = (LENW'(lane_q) == dl - LENW'(1));
    last     = lane_end && (sub_q == vl - VLW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q   <= '0;
      lane_q  <= '0;
      sbase_q <= '0;
      didx_q  <= '0;
    end else if (load) begin
      sub_q   <= '0;
      lane_q  <= '0;
      sbase_q <= '0;
      didx_q  <= '0;
    end else if (step) begin
      didx_q <= didx_q + IDXW'(1);
      if (lane_end) begin
        lane_q  <= '0;
        sub_q   <= sub_q + VLW'(1);
        sbase_q <= sbase_q + IDXW'(sl);
      end else begin
        lane_q <= lane_q + SELW'(1);
      end
    end
  end

  logic [IDXW-1:0] sidx;
  always_comb begin
    sidx    = sbase_q + IDXW'(sel[lane_q*SELW +: SELW]);
    rd_addr = src_base + (AW'(sidx) << shift);
    wr_addr = dst_base + (AW'(didx_q) << shift);
  end
endmodule

// File: rtl/swz_lane_pack.sv
module swz_lane_pack #(
  parameter int DW = 32
) (
  input  logic [1:0]    el_code,
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] elem
);
  always_comb begin
    case (el_code)
      swz_pkg::EL_B8:  elem = DW'(raw[7:0]);
      swz_pkg::EL_B16: elem = DW'(raw[15:0]);
      default:         elem = raw;
    endcase
  end
endmodule

// File: rtl/swz_engine.sv
module swz_engine #(
  parameter int AW   = 16,
  parameter int VLW  = 7,
  parameter int MAXL = 4,
  localparam int SELW = $clog2(MAXL),
  localparam int LENW = $clog2(MAXL + 1),
  localparam int DW   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [VLW-1:0]       vl,
  input  logic [LENW-1:0]      src_len,
  input  logic [LENW-1:0]      dst_len,
  input  logic [1:0]           el_code,
  input  logic [MAXL*SELW-1:0] sel,
  input  logic [AW-1:0]        src_base,
  input  logic [AW-1:0]        dst_base,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic                 rd_en,
  output logic [AW-1:0]        rd_addr,
  input  logic [DW-1:0]        rd_data,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [AW-1:0]        wr_addr,
  output logic [DW-1:0]        wr_data,
  output logic [1:0]           wr_size
);
  import swz_pkg::*;

  swz_state_t           st_q;
  logic [VLW-1:0]       vl_q;
  logic [LENW-1:0]      sl_q;
  logic [LENW-1:0]      dl_q;
  logic [1:0]           ec_q;
  logic [MAXL*SELW-1:0] sel_q;
  logic [AW-1:0]        sb_q;
  logic [AW-1:0]        db_q;
  logic                 err_q;
  logic                 cfg_bad;
  logic                 accept;
  logic                 fire;
  logic                 last;

  swz_cfg_check #(.MAXL(MAXL), .SELW(SELW), .LENW(LENW)) u_check (
    .src_len(src_len), .dst_len(dst_len), .el_code(el_code),
    .sel(sel), .bad(cfg_bad)
  );

  assign accept = start && (st_q == ST_IDLE);
  assign fire   = (st_q == ST_RUN) && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      vl_q  <= '0;
      sl_q  <= '0;
      dl_q  <= '0;
      ec_q  <= '0;
      sel_q <= '0;
      sb_q  <= '0;
      db_q  <= '0;
      err_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          vl_q  <= vl;
          sl_q  <= src_len;
          dl_q  <= dst_len;
          ec_q  <= el_code;
          sel_q <= sel;
          sb_q  <= src_base;
          db_q  <= dst_base;
          err_q <= cfg_bad;
          st_q  <= (cfg_bad || vl == '0) ? ST_FIN : ST_RUN;
        end
        ST_RUN: if (fire && last) st_q <= ST_FIN;
        default: begin
          st_q  <= ST_IDLE;
          err_q <= 1'b0;
        end
      endcase
    end
  end

  swz_addr_gen #(
    .AW(AW), .VLW(VLW), .MAXL(MAXL), .SELW(SELW), .LENW(LENW)
  ) u_addr (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(fire),
    .vl(vl_q), .sl(sl_q), .dl(dl_q), .sel(sel_q),
    .shift(size_shift(ec_q)), .src_base(sb_q), .dst_base(db_q),
    .rd_addr(rd_addr), .wr_addr(wr_addr), .last(last)
  );

  swz_lane_pack #(.DW(DW)) u_pack (
    .el_code(ec_q), .raw(rd_data), .elem(wr_data)
  );

  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_FIN);
  assign err      = done && err_q;
  assign wr_valid = (st_q == ST_RUN);
  assign rd_en    = (st_q == ST_RUN);
  assign wr_size  = ec_q;
endmodule

// File: rtl/swz_engine_chk.sv
module swz_engine_chk #(
  parameter int AW   = 16,
  parameter int VLW  = 7,
  parameter int LENW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [VLW-1:0]  vl,
  input logic [LENW-1:0] dst_len,
  input logic            busy,
  input logic            done,
  input logic            err,
  input logic            rd_en,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [AW-1:0]   wr_addr,
  input logic [31:0]     wr_data
);
  localparam int CW = VLW + LENW;
  logic [CW-1:0] wcnt;
  logic [CW-1:0] wexp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0;
      wexp <= '0;
    end else if (start && !busy) begin
      wcnt <= '0;
      wexp <= CW'(vl) * CW'(dst_len);
    end else if (wr_valid && wr_ready) begin
      wcnt <= wcnt + CW'(1);
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R10
  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid); // R10
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R7
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R9
  AST_RD_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> rd_en); // R1
  AST_WR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> wcnt == wexp); // R2
  AST_ERR_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> wcnt == '0); // R7
endmodule

bind swz_engine swz_engine_chk #(.AW(AW), .VLW(VLW), .LENW(LENW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .dst_len(dst_len),
  .busy(busy), .done(done), .err(err), .rd_en(rd_en),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data)
);

// File: tb/swz_engine_bench.sv
`timescale 1ns/1ps
module swz_engine_bench;
  localparam int AW = 16, VLW = 7, MAXL = 4;
  localparam int MB = 1024;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [VLW-1:0] vl = '0;
  logic [2:0] src_len = 3'd1, dst_len = 3'd1;
  logic [1:0] el_code = '0;
  logic [7:0] sel = '0;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic busy, done, err, rd_en, wr_valid, wr_ready;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data;
  logic [1:0] wr_size;

  logic [7:0] mem [0:MB-1];
  logic [7:0] emem [0:MB-1];
  int cyc = 0, nwr = 0, mark = 0, first_wr = 0, last_wr = 0;
  int rmode = 0;
  int n_chk = 0, n_err = 0;
  bit wd_hit = 1'b0;

  always #5 clk = ~clk;

  swz_engine #(.AW(AW), .VLW(VLW), .MAXL(MAXL)) u_swz_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .src_len(src_len),
    .dst_len(dst_len), .el_code(el_code), .sel(sel), .src_base(src_base),
    .dst_base(dst_base), .busy(busy), .done(done), .err(err),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_size(wr_size)
  );

  assign rd_data = {mem[10'(rd_addr + 16'd3)], mem[10'(rd_addr + 16'd2)],
                    mem[10'(rd_addr + 16'd1)], mem[10'(rd_addr)]};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wr_valid && wr_ready) begin
      mem[10'(wr_addr)] <= wr_data[7:0];
      if (wr_size != 2'd0) mem[10'(wr_addr + 16'd1)] <= wr_data[15:8];
      if (wr_size == 2'd2) begin
        mem[10'(wr_addr + 16'd2)] <= wr_data[23:16];
        mem[10'(wr_addr + 16'd3)] <= wr_data[31:24];
      end
      if (nwr == mark) first_wr <= cyc;
      last_wr <= cyc;
      nwr <= nwr + 1;
    end
  end

  always @(negedge clk) wr_ready = (rmode == 0) ? 1'b1 : 1'($urandom % 2);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input int v, input int sl, input int dl, input int ec,
                        input logic [7:0] sv, input int sb, input int db,
                        input int rm, input string req, input bit poke);
    int sz, nexp, scyc, t, bad_mem;
    bit bad;
    sz = 1 << ((ec > 2) ? 2 : ec);
    bad = (sl < 1) || (sl > 4) || (dl < 1) || (dl > 4) || (ec == 3);
    for (int k = 0; k < 4; k++)
      if (k < dl && int'(sv[2*k +: 2]) >= sl) bad = 1'b1;
    for (int a = 0; a < MB; a++) emem[a] = mem[a];
    nexp = bad ? 0 : v * dl;
    if (!bad)
      for (int i = 0; i < v; i++)
        for (int k = 0; k < dl; k++)
          for (int b = 0; b < sz; b++)
            emem[(db + (i*dl + k)*sz + b) % MB] =
              mem[(sb + (i*sl + int'(sv[2*k +: 2]))*sz + b) % MB];
    rmode = rm;
    @(negedge clk);
    mark = nwr;
    vl = VLW'(v); src_len = 3'(sl); dst_len = 3'(dl); el_code = 2'(ec);
    sel = sv; src_base = AW'(sb); dst_base = AW'(db);
    start = 1'b1; scyc = cyc;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R10", "busy after start", busy, 1);
    if (poke && !done) begin
      // R11: a second start with another setup while busy
      vl = 7'd9; dst_len = 3'd1; sel = 8'h00; src_base = 16'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    chk(done == 1'b1, req, "done reached", done, 1);
    chk(err == bad, bad ? "R7/R8" : req, "err flag", err, bad);
    chk(nwr - mark == nexp, bad ? "R7" : "R2", "write count", nwr - mark, nexp);
    if (nexp > 0)
      chk(cyc == last_wr + 1, "R10", "done after last write", cyc, last_wr + 1);
    else
      chk(cyc == scyc + 1, v == 0 ? "R12" : "R7", "done cycle", cyc, scyc + 1);
    if (rm == 0 && nexp > 0)
      chk(last_wr - first_wr == nexp - 1, "R9", "one write per clock",
          last_wr - first_wr, nexp - 1);
    @(negedge clk);
    bad_mem = 0;
    for (int a = 0; a < MB; a++) if (mem[a] !== emem[a]) bad_mem++;
    chk(bad_mem == 0, req, "memory image mismatches", bad_mem, 0);
    chk(done == 1'b0 && busy == 1'b0, "R10", "done pulse ends", done, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < MB; a++) mem[a] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !wr_valid, "R13", "reset outputs",
        {busy, done, err, wr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wr_valid, "R13", "idle after reset", busy, 0);
    // sel lanes packed as {k3,k2,k1,k0}, 2 bits each
    run_op(5, 3, 4, 0, {2'd1, 2'd2, 2'd0, 2'd0}, 16, 600, 0, "R1/R4/R6", 0);
    run_op(5, 4, 1, 2, {2'd0, 2'd0, 2'd0, 2'd2}, 0, 520, 0, "R3", 0);
    run_op(4, 2, 3, 1, {2'd0, 2'd1, 2'd0, 2'd1}, 40, 700, 0, "R5", 0);
    run_op(6, 4, 4, 2, {2'd0, 2'd1, 2'd2, 2'd3}, 8, 512, 0, "R4", 0);
    run_op(0, 3, 2, 0, 8'h00, 0, 512, 0, "R12", 0);
    run_op(3, 3, 2, 0, {2'd0, 2'd0, 2'd3, 2'd0}, 0, 512, 0, "R7", 0);
    run_op(4, 2, 1, 0, {2'd3, 2'd3, 2'd3, 2'd1}, 0, 800, 0, "R7", 0);
    run_op(2, 0, 2, 0, 8'h00, 0, 512, 0, "R8", 0);
    run_op(2, 5, 2, 0, 8'h00, 0, 512, 0, "R8", 0);
    run_op(2, 2, 2, 3, 8'h00, 0, 512, 0, "R8", 0);
    run_op(12, 3, 4, 1, {2'd2, 2'd1, 2'd0, 2'd2}, 4, 560, 1, "R9", 0);
    run_op(8, 4, 2, 0, {2'd3, 2'd3, 2'd1, 2'd0}, 30, 620, 0, "R11", 1);
    for (int n = 0; n < 40; n++) begin
      int sl, dl;
      logic [7:0] sv;
      sl = 1 + int'($urandom % 4);
      dl = 1 + int'($urandom % 4);
      sv = '0;
      for (int k = 0; k < 4; k++) sv[2*k +: 2] = 2'($urandom % sl);
      if ($urandom % 8 == 0) sv[1:0] = 2'd3;
      run_op(int'($urandom % 21), sl, dl, int'($urandom % 3), sv,
             int'($urandom % 128), 512 + int'($urandom % 128),
             int'($urandom % 2), "R1/R2", 0);
    end
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    wd_hit = 1'b1;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule